// File: doc/BRIEF.md
# MSI Doorbell Frame

This block is a small memory-mapped frame that converts message-signalled interrupt writes into single-cycle pulses on a contiguous range of shared interrupt lines. A bus master raises an interrupt by writing the absolute interrupt number to the doorbell word. If that number falls inside the range the frame owns, the matching output line pulses high for one cycle. That line feeds an edge-triggered input of the interrupt distributor.

The range is fixed at build time by two parameters, the first owned interrupt number and the number of owned interrupts. Software reads both back from a read-only type word. A write whose number lies outside the range never wraps onto a line. It is dropped, and a sticky error flag records it. The bus transfer itself still completes normally, with no error response.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While `rstN` is low, every bit of `spiPulse` is 0, `errFlag` is 0 and `busRdData` is 0. Reset is asynchronous and active low.
- R2: A read strobe at byte offset 0x008 returns the type word on `busRdData` in the following cycle. Bits [25:16] hold `SPI_BASE`, bits [9:0] hold `SPI_COUNT`, and all other bits are 0.
- R3: A write at byte offset 0x040 with a data value v where `SPI_BASE` <= v < `SPI_BASE+SPI_COUNT` drives bit (v − `SPI_BASE`) of `spiPulse` high in the cycle after the write. All other bits stay low.
- R4: A line that pulses is low again one cycle later unless a new doorbell write targets it. With no doorbell write in the previous cycle, `spiPulse` is all zero.
- R5: A doorbell write with v below `SPI_BASE`, or with v at or above `SPI_BASE+SPI_COUNT`, raises no line. This includes values whose upper bits are nonzero. Such a write sets `errFlag` in the next cycle.
- R6: `errFlag` stays set until reset. Later in-range writes do not clear it.
- R7: Doorbell writes in consecutive cycles each give their own one-cycle pulse. Two writes to the same number keep that line high for two cycles. Writes to different numbers move the single high bit from line to line, one line per cycle.
- R8: A read of the doorbell offset 0x040, or of any offset other than 0x008, returns 0 in the following cycle. In a cycle after no read, `busRdData` is 0.
- R9: A write to the type offset 0x008 or to any other offset except 0x040 raises no line and leaves `errFlag` unchanged. The type word then reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one transfer per cycle |
| busRdEn | input | 1 | Read strobe, one transfer per cycle |
| busAddr | input | ADDR_W | Byte offset inside the frame |
| busWrData | input | 32 | Write data; for the doorbell, the absolute interrupt number |
| busRdData | output | 32 | Read data, valid the cycle after `busRdEn` |
| spiPulse | output | SPI_COUNT | One-cycle pulses, bit i for interrupt `SPI_BASE`+i |
| errFlag | output | 1 | Sticky flag for out-of-range doorbell writes |

## Verification
The state inside this block is a pulse register, one sticky flag and a read-data register, so any fault in that state reaches the ports within one cycle of the write or read that exposes it. A decode or offset fault puts the high bit on the wrong line, or on two lines, right after the write. A pulse register that fails to clear leaves a line high in the following idle cycle. A range check that wraps or has an off-by-one error shows up at the two boundary values and at a value with high bits set: a line fires where none should, or `errFlag` fails to rise. A flag that is not sticky drops on the next in-range write.

// File: rtl/msi_doorbell_pkg.sv
package msi_doorbell_pkg;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;
  localparam logic [11:0] TYPE_OFS = 12'h008;
  localparam logic [11:0] RING_OFS = 12'h040;

  typedef struct packed {
    logic            fire;
    logic [ID_W-1:0] id;
    logic            miss;
    logic            rdType;
  } strobe_t;
endpackage

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_doorbell_pkg::*;
#(
  parameter int SPI_BASE  = 64,
  parameter int SPI_COUNT = 16,
  parameter int ADDR_W    = 12
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output strobe_t           strb
);
  localparam logic [DATA_W-1:0] LO_ID = DATA_W'(SPI_BASE);
  localparam logic [DATA_W-1:0] HI_ID = DATA_W'(SPI_BASE + SPI_COUNT);

  logic isRing;
  logic isType;
  logic inRange;
  logic [DATA_W-1:0] offsetId;

  always_comb begin
    isRing   = (busAddr == ADDR_W'(RING_OFS));
    isType   = (busAddr == ADDR_W'(TYPE_OFS));
    inRange  = (busWrData >= LO_ID) && (busWrData < HI_ID);
    offsetId = busWrData - LO_ID;

    strb.fire   = busWrEn && isRing && inRange;
    strb.miss   = busWrEn && isRing && !inRange;
    strb.id     = ID_W'(offsetId);
    strb.rdType = busRdEn && isType;
  end
endmodule

// File: rtl/msi_doorbell_dp.sv
module msi_doorbell_dp
  import msi_doorbell_pkg::*;
#(
  parameter int SPI_BASE  = 64,
  parameter int SPI_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  output logic [SPI_COUNT-1:0] spiPulse,
  output logic                 errFlag,
  output logic [DATA_W-1:0]    busRdData
);
  localparam logic [DATA_W-1:0] TYPE_WORD =
    {6'd0, ID_W'(SPI_BASE), 6'd0, ID_W'(SPI_COUNT)};

  logic [SPI_COUNT-1:0] pulseQ;
  logic                 errQ;
  logic [DATA_W-1:0]    rdQ;

  for (genvar g = 0; g < SPI_COUNT; g++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ[g] <= 1'b0;
      else       pulseQ[g] <= strb.fire && (strb.id == ID_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      rdQ  <= '0;
    end else begin
      errQ <= errQ || strb.miss;
      rdQ  <= strb.rdType ? TYPE_WORD : '0;
    end
  end

  assign spiPulse  = pulseQ;
  assign errFlag   = errQ;
  assign busRdData = rdQ;
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
  import msi_doorbell_pkg::*;
#(
  parameter int SPI_BASE  = 64,
  parameter int SPI_COUNT = 16,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic [SPI_COUNT-1:0] spiPulse,
  output logic                 errFlag
);
  strobe_t strb;

  msi_doorbell_ctrl #(
    .SPI_BASE (SPI_BASE),
    .SPI_COUNT(SPI_COUNT),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strb     (strb)
  );

  msi_doorbell_dp #(
    .SPI_BASE (SPI_BASE),
    .SPI_COUNT(SPI_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .spiPulse (spiPulse),
    .errFlag  (errFlag),
    .busRdData(busRdData)
  );
endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
  parameter int SPI_BASE  = 64,
  parameter int SPI_COUNT = 16,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic [SPI_COUNT-1:0] spiPulse,
  input logic                 errFlag
);
  logic ringWr;
  logic hitWr;
  assign ringWr = busWrEn && (busAddr == ADDR_W'(12'h040));
  assign hitWr  = ringWr && (busWrData >= 32'(SPI_BASE))
                         && (busWrData < 32'(SPI_BASE + SPI_COUNT));

  // R3, R7: never more than one line at a time
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spiPulse));

  // R3: an in-range doorbell write raises exactly one line
  a_r3_hit_pulses: assert property (@(posedge clk) disable iff (!rstN)
    hitWr |=> ($countones(spiPulse) == 1));

  // R4, R9: without a doorbell write, all lines are low
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !ringWr |=> (spiPulse == '0));

  // R5: an out-of-range write is dropped and flagged
  a_r5_miss_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ringWr && !hitWr) |=> ((spiPulse == '0) && errFlag));

  // R6: the flag is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8: the doorbell reads as zero
  a_r8_ring_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(12'h040)) |=> (busRdData == '0));

  // R2: the type word is stable across reads
  a_r2_type_word: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(12'h008)) |=>
      (busRdData == {6'd0, 10'(SPI_BASE), 6'd0, 10'(SPI_COUNT)}));
endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(
  .SPI_BASE (SPI_BASE),
  .SPI_COUNT(SPI_COUNT),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .spiPulse (spiPulse),
  .errFlag  (errFlag)
);

// File: tb/msi_doorbell_frame_bench.sv
module msi_doorbell_frame_bench;
  localparam int BASE  = 64;
  localparam int COUNT = 16;
  localparam int NVEC  = 14;
  localparam logic [31:0] TYPE_EXP = 32'h0040_0010;

  typedef struct packed {
    logic        isWr;
    logic        isRd;
    logic [11:0] addr;
    logic [31:0] data;
    logic        expHit;
    logic [3:0]  expIdx;
    logic        expErr;
    logic [31:0] expRd;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 12'h008, 32'd0,          1'b0, 4'd0,  1'b0, TYPE_EXP}, // R2
    '{1'b1, 1'b0, 12'h040, 32'd64,         1'b1, 4'd0,  1'b0, 32'd0},    // R3 low edge
    '{1'b1, 1'b0, 12'h040, 32'd79,         1'b1, 4'd15, 1'b0, 32'd0},    // R3 high edge
    '{1'b1, 1'b0, 12'h040, 32'd70,         1'b1, 4'd6,  1'b0, 32'd0},    // R7
    '{1'b1, 1'b0, 12'h040, 32'd70,         1'b1, 4'd6,  1'b0, 32'd0},    // R7 repeat
    '{1'b0, 1'b0, 12'h000, 32'd0,          1'b0, 4'd0,  1'b0, 32'd0},    // R4
    '{1'b0, 1'b1, 12'h040, 32'd0,          1'b0, 4'd0,  1'b0, 32'd0},    // R8
    '{1'b1, 1'b0, 12'h008, 32'hFFFF_FFFF,  1'b0, 4'd0,  1'b0, 32'd0},    // R9
    '{1'b0, 1'b1, 12'h008, 32'd0,          1'b0, 4'd0,  1'b0, TYPE_EXP}, // R9
    '{1'b1, 1'b0, 12'h044, 32'd70,         1'b0, 4'd0,  1'b0, 32'd0},    // R9
    '{1'b1, 1'b0, 12'h040, 32'd63,         1'b0, 4'd0,  1'b1, 32'd0},    // R5 below
    '{1'b1, 1'b0, 12'h040, 32'd72,         1'b1, 4'd8,  1'b1, 32'd0},    // R6
    '{1'b1, 1'b0, 12'h040, 32'd80,         1'b0, 4'd0,  1'b1, 32'd0},    // R5 above
    '{1'b0, 1'b1, 12'h010, 32'd0,          1'b0, 4'd0,  1'b1, 32'd0}     // R8 other
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [COUNT-1:0] spiPulse;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_doorbell_frame #(
    .SPI_BASE (BASE),
    .SPI_COUNT(COUNT),
    .ADDR_W   (12)
  ) u_msi_doorbell_frame (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .spiPulse(spiPulse), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", 32'(spiPulse), 32'd0);
    chk("R1 reset err", 32'(errFlag), 32'd0);
    chk("R1 reset rd", busRdData, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].isWr, VECS[i].isRd, VECS[i].addr, VECS[i].data);
      @(negedge clk);
      chk($sformatf("R3/R4/R5/R7/R9 pulse vec%0d", i), 32'(spiPulse),
          VECS[i].expHit ? (32'd1 << VECS[i].expIdx) : 32'd0);
      chk($sformatf("R5/R6 err vec%0d", i), 32'(errFlag), 32'(VECS[i].expErr));
      chk($sformatf("R2/R8 rd vec%0d", i), busRdData, VECS[i].expRd);
    end
    drive(1'b0, 1'b0, 12'h000, 32'd0);
    @(negedge clk);

    // R1: asynchronous reset mid-run clears the sticky flag
    rstN = 1'b0;
    #1;
    chk("R1 async err", 32'(errFlag), 32'd0);
    chk("R1 async pulse", 32'(spiPulse), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R5: upper bits set must not wrap onto a line
    drive(1'b1, 1'b0, 12'h040, 32'hFFFF_0040);
    @(negedge clk);
    chk("R5 wrap pulse", 32'(spiPulse), 32'd0);
    chk("R5 wrap err", 32'(errFlag), 32'd1);
    drive(1'b1, 1'b0, 12'h040, 32'd64);
    @(negedge clk);
    chk("R3 after reset", 32'(spiPulse), 32'd1);
    drive(1'b0, 1'b0, 12'h000, 32'd0);
    @(negedge clk);
    chk("R4 clears", 32'(spiPulse), 32'd0);
    chk("R6 still set", 32'(errFlag), 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule